// File: doc/BRIEF.md
# Rotate, Return and Sleep Execute Unit

This block is the execute stage of a small 8-bit controller core. It takes one 14-bit instruction word per cycle, marked by a valid strobe, and acts on four opcodes: rotate a data register right or left through the carry flag, return from a subroutine, and enter the low-power sleep state. It owns the architectural state those opcodes touch: a register file, the working register W, the carry flag, the time-out and power-down status bits, the program counter, a circular return-address stack and a watchdog counter with its prescaler.

A rotate reads one register, shifts it one place with the carry flag filling the vacated bit, and writes the result either to W or back to the register. A return takes two cycles, and the unit stalls through the second one. Sleep stops all execution and freezes the watchdog until a wake request arrives. Any other word only advances the program counter. The register file and the return stack reset to computed seed patterns, so the rotates and returns give known results straight after reset.

Top module: `rrs_exec_unit`

## Requirements
- R1: An instruction is accepted on a rising clock edge where instr_valid is 1 and busy is 0. Decoding uses the 14-bit word: bits 13:8 = 001100 is rotate right, bits 13:8 = 001101 is rotate left, 0x0008 is return, 0x0063 is sleep. In a rotate, bits 6:0 address the register and bit 7 is the destination select.
- R2: Rotate right gives {C, f[7:1]} as its result and loads f[0] into C.
- R3: Rotate left gives {f[6:0], C} as its result and loads f[7] into C.
- R4: When the destination bit is 0, the rotate result goes to W and the register is left unchanged. When the bit is 1, the result goes back to the register and W is left unchanged. A rotate changes no status bit other than C.
- R5: On reset, data register n is loaded with (37*n + 90) mod 256.
- R6: A return is accepted in one cycle. busy is then 1 for exactly the next cycle, and any instruction offered during that cycle is ignored. At the end of that cycle the PC is loaded with the popped address. W, C, TO and PD do not change.
- R7: The return stack has 8 entries and a 3-bit pointer that reset clears. Entry k resets to (291*k + 64) mod 8192. A pop first decrements the pointer modulo 8 and then reads the entry it points to, so the first pop after reset returns entry 7 (address 2101).
- R8: An accepted sleep clears the watchdog counter and the prescaler, sets TO, clears PD, raises asleep and busy, and advances the PC by 1.
- R9: While asleep, offered instructions are ignored. The PC, W, C and the register file hold their values, and the watchdog and prescaler stay frozen.
- R10: When wake_req is 1 while asleep, asleep and busy fall at the next edge and the PC is unchanged. An instruction offered in that same cycle is ignored. The watchdog resumes counting one cycle later.
- R11: Any word that is not one of the four opcodes is a one-cycle no-op. It advances the PC by 1 and changes nothing else.
- R12: Reset clears W, C, the PC and the stack pointer, sets TO and PD, and leaves busy and asleep at 0.
- R13: The PC advances by 1, modulo 2^13, on each accepted rotate, sleep or no-op. It holds when no instruction is accepted and no return is completing.
- R14: While not asleep, the 4-bit prescaler increments every cycle, and the 8-bit watchdog counter increments when the prescaler wraps. The two read together as one 12-bit count that grows by 1 per awake cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | An instruction word is offered this cycle |
| instr_word | input | 14 | Instruction word |
| wake_req | input | 1 | Leave the sleep state |
| busy | output | 1 | Stall: second cycle of a return, or asleep |
| asleep | output | 1 | Sleep state indication |
| pc | output | PC_W (13) | Current program counter |
| w_reg | output | DATA_W (8) | Working register |
| carry | output | 1 | Carry flag |
| to_flag | output | 1 | Time-out status bit |
| pd_flag | output | 1 | Power-down status bit |
| wdt_count | output | WDT_W (8) | Watchdog counter |
| wdt_prescale | output | PRE_W (4) | Watchdog prescaler |

## Verification
The properties assume that an offered word counts as accepted exactly when busy is low in the same cycle. They also assume that wake_req only matters while asleep, and that the return state lasts one cycle because nothing upstream can extend it. The stimulus drives every input on the falling edge and changes the instruction only between accepted cycles. It offers words while busy on purpose, to exercise the ignore paths, and it raises wake_req only while the unit is asleep. The expected register, carry and stack values come from the seed formulas and the rotate arithmetic, computed in the bench.

// File: rtl/rrs_pkg.sv
`timescale 1ns/1ps
package rrs_pkg;

   localparam int INSTR_W = 14;
   localparam int FADDR_W = 7;

   localparam logic [5:0]         ROT_R_HI  = 6'b001100;
   localparam logic [5:0]         ROT_L_HI  = 6'b001101;
   localparam logic [INSTR_W-1:0] RET_WORD  = 14'h0008;
   localparam logic [INSTR_W-1:0] SLP_WORD  = 14'h0063;

   typedef enum logic [2:0] {
      OP_NOP,
      OP_RRF,
      OP_RLF,
      OP_RET,
      OP_SLP
   } op_e;

   typedef enum logic [1:0] {
      ST_RUN,
      ST_RET,
      ST_SLEEP
   } ex_state_e;

   typedef struct packed {
      op_e                op;
      logic               dest;
      logic [FADDR_W-1:0] faddr;
   } dec_t;

endpackage

// File: rtl/rrs_decode.sv
`timescale 1ns/1ps
module rrs_decode
   import rrs_pkg::*;
(
   input  logic [INSTR_W-1:0] word,
   output dec_t               dec
);

   always_comb begin
      dec.dest  = word[FADDR_W];
      dec.faddr = word[FADDR_W-1:0];
      if (word[INSTR_W-1:8] == ROT_R_HI)      dec.op = OP_RRF;
      else if (word[INSTR_W-1:8] == ROT_L_HI) dec.op = OP_RLF;
      else if (word == RET_WORD)              dec.op = OP_RET;
      else if (word == SLP_WORD)              dec.op = OP_SLP;
      else                                    dec.op = OP_NOP;
   end

endmodule

// File: rtl/rrs_regfile.sv
`timescale 1ns/1ps
module rrs_regfile #(
   parameter int DATA_W   = 8,
   parameter int DEPTH    = 128,
   parameter int SEED_MUL = 37,
   parameter int SEED_ADD = 90,
   localparam int AW      = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data
);

   logic [DATA_W-1:0] cell_vec [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      localparam longint unsigned INIT_V =
         (longint'(i) * SEED_MUL + SEED_ADD) % (longint'(1) << DATA_W);
      logic [DATA_W-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q <= DATA_W'(INIT_V);
         else if (wr_en && (wr_addr == AW'(i)))
            cell_q <= wr_data;
      end
      assign cell_vec[i] = cell_q;
   end

   assign rd_data = cell_vec[rd_addr];

endmodule

// File: rtl/rrs_ret_stack.sv
`timescale 1ns/1ps
module rrs_ret_stack #(
   parameter int PC_W     = 13,
   parameter int DEPTH    = 8,
   parameter int SEED_MUL = 291,
   parameter int SEED_ADD = 64,
   localparam int SP_W    = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pop,
   output logic [PC_W-1:0] pop_addr
);

   logic [PC_W-1:0] entry_vec [DEPTH];
   logic [SP_W-1:0] sp_q;
   logic [SP_W-1:0] sp_dn;

   for (genvar k = 0; k < DEPTH; k++) begin : g_entry
      localparam longint unsigned INIT_V =
         (longint'(k) * SEED_MUL + SEED_ADD) % (longint'(1) << PC_W);
      assign entry_vec[k] = PC_W'(INIT_V);
   end

   assign sp_dn    = sp_q - SP_W'(1);
   assign pop_addr = entry_vec[sp_dn];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sp_q <= '0;
      else if (pop) sp_q <= sp_dn;
   end

endmodule

// File: rtl/rrs_watchdog.sv
`timescale 1ns/1ps
module rrs_watchdog #(
   parameter int PRE_W = 4,
   parameter int WDT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clear,
   output logic [PRE_W-1:0] pre_q,
   output logic [WDT_W-1:0] cnt_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (clear) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (run) begin
         pre_q <= pre_q + PRE_W'(1);
         if (&pre_q) cnt_q <= cnt_q + WDT_W'(1);
      end
   end

endmodule

// File: rtl/rrs_exec_unit.sv
`timescale 1ns/1ps
module rrs_exec_unit
   import rrs_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int REG_DEPTH    = 128,
   parameter int PC_W         = 13,
   parameter int STACK_DEPTH  = 8,
   parameter int PRE_W        = 4,
   parameter int WDT_W        = 8,
   parameter int RF_SEED_MUL  = 37,
   parameter int RF_SEED_ADD  = 90,
   parameter int STK_SEED_MUL = 291,
   parameter int STK_SEED_ADD = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_valid,
   input  logic [INSTR_W-1:0] instr_word,
   input  logic               wake_req,
   output logic               busy,
   output logic               asleep,
   output logic [PC_W-1:0]    pc,
   output logic [DATA_W-1:0]  w_reg,
   output logic               carry,
   output logic               to_flag,
   output logic               pd_flag,
   output logic [WDT_W-1:0]   wdt_count,
   output logic [PRE_W-1:0]   wdt_prescale
);

   localparam int RF_AW = $clog2(REG_DEPTH);
   localparam int SP_W  = $clog2(STACK_DEPTH);

   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (REG_DEPTH > (1 << FADDR_W) || (1 << RF_AW) != REG_DEPTH) begin : g_bad_rf
      $error("REG_DEPTH must be a power of two no larger than the address field");
   end
   if (STACK_DEPTH < 2 || (1 << SP_W) != STACK_DEPTH) begin : g_bad_stk
      $error("STACK_DEPTH must be a power of two of at least 2");
   end
   if (PC_W < 2 || PC_W > 24) begin : g_bad_pc
      $error("PC_W out of range");
   end

   dec_t              dec;
   ex_state_e         state_q;
   logic              accept;
   logic              is_rot;
   logic [RF_AW-1:0]  rf_addr;
   logic [DATA_W-1:0] rf_q;
   logic [DATA_W-1:0] rot_res;
   logic              rot_c;
   logic              rf_we;
   logic              stk_pop;
   logic [PC_W-1:0]   stk_addr;
   logic [PC_W-1:0]   ret_hold_q;
   logic [PC_W-1:0]   pc_q;
   logic [DATA_W-1:0] w_q;
   logic              c_q;
   logic              to_q;
   logic              pd_q;

   rrs_decode u_dec (
      .word (instr_word),
      .dec  (dec)
   );

   if (RF_AW == FADDR_W) begin : g_full_addr
      assign rf_addr = dec.faddr;
   end else begin : g_part_addr
      assign rf_addr = dec.faddr[RF_AW-1:0];
   end

   assign accept  = instr_valid && (state_q == ST_RUN);
   assign is_rot  = (dec.op == OP_RRF) || (dec.op == OP_RLF);
   assign rf_we   = accept && is_rot && dec.dest;
   assign stk_pop = accept && (dec.op == OP_RET);

   always_comb begin
      if (dec.op == OP_RRF) begin
         rot_res = {c_q, rf_q[DATA_W-1:1]};
         rot_c   = rf_q[0];
      end else begin
         rot_res = {rf_q[DATA_W-2:0], c_q};
         rot_c   = rf_q[DATA_W-1];
      end
   end

   rrs_regfile #(
      .DATA_W   (DATA_W),
      .DEPTH    (REG_DEPTH),
      .SEED_MUL (RF_SEED_MUL),
      .SEED_ADD (RF_SEED_ADD)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (rf_addr),
      .rd_data (rf_q),
      .wr_en   (rf_we),
      .wr_addr (rf_addr),
      .wr_data (rot_res)
   );

   rrs_ret_stack #(
      .PC_W     (PC_W),
      .DEPTH    (STACK_DEPTH),
      .SEED_MUL (STK_SEED_MUL),
      .SEED_ADD (STK_SEED_ADD)
   ) u_stk (
      .clk      (clk),
      .rst_n    (rst_n),
      .pop      (stk_pop),
      .pop_addr (stk_addr)
   );

   rrs_watchdog #(
      .PRE_W (PRE_W),
      .WDT_W (WDT_W)
   ) u_wdt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state_q != ST_SLEEP),
      .clear (accept && (dec.op == OP_SLP)),
      .pre_q (wdt_prescale),
      .cnt_q (wdt_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
      end else begin
         unique case (state_q)
            ST_RUN: begin
               if (stk_pop)                            state_q <= ST_RET;
               else if (accept && (dec.op == OP_SLP))  state_q <= ST_SLEEP;
            end
            ST_RET:   state_q <= ST_RUN;
            ST_SLEEP: if (wake_req) state_q <= ST_RUN;
            default:  state_q <= ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q       <= '0;
         ret_hold_q <= '0;
      end else begin
         if (stk_pop)
            ret_hold_q <= stk_addr;
         if (state_q == ST_RET)
            pc_q <= ret_hold_q;
         else if (accept && (dec.op != OP_RET))
            pc_q <= pc_q + PC_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_q  <= '0;
         c_q  <= 1'b0;
         to_q <= 1'b1;
         pd_q <= 1'b1;
      end else if (accept) begin
         if (is_rot) begin
            c_q <= rot_c;
            if (!dec.dest) w_q <= rot_res;
         end
         if (dec.op == OP_SLP) begin
            to_q <= 1'b1;
            pd_q <= 1'b0;
         end
      end
   end

   assign busy    = (state_q != ST_RUN);
   assign asleep  = (state_q == ST_SLEEP);
   assign pc      = pc_q;
   assign w_reg   = w_q;
   assign carry   = c_q;
   assign to_flag = to_q;
   assign pd_flag = pd_q;

endmodule

// File: rtl/rrs_exec_chk.sv
`timescale 1ns/1ps
module rrs_exec_chk #(
   parameter int DATA_W = 8,
   parameter int PC_W   = 13,
   parameter int PRE_W  = 4,
   parameter int WDT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_valid,
   input logic [13:0]       instr_word,
   input logic              wake_req,
   input logic              busy,
   input logic              asleep,
   input logic [PC_W-1:0]   pc,
   input logic [DATA_W-1:0] w_reg,
   input logic              carry,
   input logic              to_flag,
   input logic              pd_flag,
   input logic [WDT_W-1:0]  wdt_count,
   input logic [PRE_W-1:0]  wdt_prescale
);

   // R6
   ret_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !busy && instr_word == 14'h0008) |=> (busy && !asleep));

   // R6
   ret_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !asleep) |=> !busy);

   // R6
   ret_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !busy && instr_word == 14'h0008)
      |=> ($stable(w_reg) && $stable(carry) && $stable(to_flag) && $stable(pd_flag)));

   // R13
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !busy && instr_word != 14'h0008) |=> (pc == $past(pc) + PC_W'(1)));

   // R13
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!instr_valid && !busy) |=> ($stable(pc) && $stable(w_reg) && $stable(carry)));

   // R8
   sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !busy && instr_word == 14'h0063)
      |=> (asleep && busy && to_flag && !pd_flag && wdt_count == '0 && wdt_prescale == '0));

   // R9
   sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && !wake_req)
      |=> (asleep && $stable(pc) && $stable(w_reg) && $stable(carry) && $stable(wdt_prescale)));

   // R10
   wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && wake_req) |=> (!asleep && !busy && $stable(pc)));

   // R4
   rot_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !busy && instr_word != 14'h0063) |=> ($stable(to_flag) && $stable(pd_flag)));

   // R9
   sleep_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> busy);

endmodule

bind rrs_exec_unit rrs_exec_chk #(
   .DATA_W (DATA_W),
   .PC_W   (PC_W),
   .PRE_W  (PRE_W),
   .WDT_W  (WDT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .instr_valid  (instr_valid),
   .instr_word   (instr_word),
   .wake_req     (wake_req),
   .busy         (busy),
   .asleep       (asleep),
   .pc           (pc),
   .w_reg        (w_reg),
   .carry        (carry),
   .to_flag      (to_flag),
   .pd_flag      (pd_flag),
   .wdt_count    (wdt_count),
   .wdt_prescale (wdt_prescale)
);

// File: tb/rrs_exec_unit_bench.sv
`timescale 1ns/1ps
module rrs_exec_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [13:0] instr_word = '0;
   logic        wake_req = 1'b0;
   logic        busy, asleep, carry, to_flag, pd_flag;
   logic [12:0] pc;
   logic [7:0]  w_reg, wdt_count;
   logic [3:0]  wdt_prescale;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [7:0]  m_rf [128];
   logic        m_c;
   logic [7:0]  m_w;
   logic [12:0] m_pc;
   logic [2:0]  m_sp;

   always #2 clk = ~clk;

   rrs_exec_unit u_rrs_exec_unit (
      .clk          (clk),
      .rst_n        (rst_n),
      .instr_valid  (instr_valid),
      .instr_word   (instr_word),
      .wake_req     (wake_req),
      .busy         (busy),
      .asleep       (asleep),
      .pc           (pc),
      .w_reg        (w_reg),
      .carry        (carry),
      .to_flag      (to_flag),
      .pd_flag      (pd_flag),
      .wdt_count    (wdt_count),
      .wdt_prescale (wdt_prescale)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // offer one word for one edge; returns at the following falling edge
   task automatic offer(input logic [13:0] word);
      instr_valid = 1'b1;
      instr_word  = word;
      @(negedge clk);
      instr_valid = 1'b0;
   endtask

   function automatic logic [13:0] rot_word(input bit left, input bit d, input int f);
      return {5'b00110, left, d, 7'(f)};
   endfunction

   task automatic do_rotate(input bit left, input bit d, input int f, input string req);
      logic [7:0] res;
      logic       nc;
      if (left) begin
         res = {m_rf[f][6:0], m_c};
         nc  = m_rf[f][7];
      end else begin
         res = {m_c, m_rf[f][7:1]};
         nc  = m_rf[f][0];
      end
      offer(rot_word(left, d, f));
      m_c  = nc;
      m_pc = m_pc + 13'd1;
      if (d) m_rf[f] = res;
      else   m_w = res;
      chk({req, " w"}, 32'(w_reg), 32'(m_w));
      chk({req, " c"}, 32'(carry), 32'(m_c));
      chk({req, " pc"}, 32'(pc), 32'(m_pc));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [11:0] wd0;
      for (int i = 0; i < 128; i++) m_rf[i] = 8'((i * 37 + 90) % 256);
      m_c = 1'b0; m_w = '0; m_pc = '0; m_sp = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      chk("R12 pc", 32'(pc), 0);
      chk("R12 w", 32'(w_reg), 0);
      chk("R12 c", 32'(carry), 0);
      chk("R12 to", 32'(to_flag), 1);
      chk("R12 pd", 32'(pd_flag), 1);
      chk("R12 busy", 32'(busy), 0);
      chk("R12 asleep", 32'(asleep), 0);

      // R5 R2 R1: rotate right into W over every register
      for (int f = 0; f < 128; f++) do_rotate(1'b0, 1'b0, f, "R2");
      // R3: rotate left into W over every register
      for (int f = 0; f < 128; f++) do_rotate(1'b1, 1'b0, f, "R3");
      // R4: rotate left back into the register, W must hold
      for (int f = 0; f < 128; f++) do_rotate(1'b1, 1'b1, f, "R4");
      // R4 R5: read back stored values through W
      for (int f = 127; f >= 0; f--) do_rotate(1'b0, 1'b0, f, "R4 readback");

      // R11: other words are no-ops
      begin
         logic [13:0] nops [6] = '{14'h3FFF, 14'h0000, 14'h0009, 14'h0062, 14'h1C05, 14'h0064};
         for (int k = 0; k < 6; k++) begin
            offer(nops[k]);
            m_pc = m_pc + 13'd1;
            chk("R11 pc", 32'(pc), 32'(m_pc));
            chk("R11 w", 32'(w_reg), 32'(m_w));
            chk("R11 c", 32'(carry), 32'(m_c));
            chk("R11 busy", 32'(busy), 0);
         end
      end

      // R13: no valid, PC holds
      repeat (5) @(negedge clk);
      chk("R13 idle pc", 32'(pc), 32'(m_pc));

      // R14: watchdog grows by one per awake cycle
      wd0 = {wdt_count, wdt_prescale};
      repeat (40) @(negedge clk);
      chk("R14 watchdog", 32'({wdt_count, wdt_prescale}), 32'(12'(wd0 + 12'd40)));

      // R6 R7: ten returns, wrapping the stack pointer
      for (int k = 0; k < 10; k++) begin
         logic [12:0] old_pc;
         old_pc = pc;
         offer(14'h0008);
         m_sp = m_sp - 3'd1;
         m_pc = 13'((int'(m_sp) * 291 + 64) % 8192);
         chk("R6 busy", 32'(busy), 1);
         chk("R6 pc hold", 32'(pc), 32'(old_pc));
         offer(rot_word(1'b0, 1'b0, k));  // ignored while busy
         chk("R7 pc", 32'(pc), 32'(m_pc));
         chk("R6 busy off", 32'(busy), 0);
         chk("R6 w", 32'(w_reg), 32'(m_w));
         chk("R6 c", 32'(carry), 32'(m_c));
         chk("R6 to", 32'(to_flag), 1);
         chk("R6 pd", 32'(pd_flag), 1);
      end

      // R8: sleep
      repeat (7) @(negedge clk);
      offer(14'h0063);
      m_pc = m_pc + 13'd1;
      chk("R8 asleep", 32'(asleep), 1);
      chk("R8 busy", 32'(busy), 1);
      chk("R8 to", 32'(to_flag), 1);
      chk("R8 pd", 32'(pd_flag), 0);
      chk("R8 wdt", 32'({wdt_count, wdt_prescale}), 0);
      chk("R8 pc", 32'(pc), 32'(m_pc));

      // R9: instructions ignored while asleep
      for (int k = 0; k < 4; k++) offer(rot_word(k[0], 1'b0, k + 3));
      offer(14'h0008);
      chk("R9 pc", 32'(pc), 32'(m_pc));
      chk("R9 w", 32'(w_reg), 32'(m_w));
      chk("R9 c", 32'(carry), 32'(m_c));
      chk("R9 wdt", 32'({wdt_count, wdt_prescale}), 0);
      chk("R9 asleep", 32'(asleep), 1);

      // R10: wake, with an instruction offered in the same cycle
      wake_req = 1'b1;
      offer(rot_word(1'b1, 1'b0, 9));
      wake_req = 1'b0;
      chk("R10 asleep", 32'(asleep), 0);
      chk("R10 busy", 32'(busy), 0);
      chk("R10 pc", 32'(pc), 32'(m_pc));
      chk("R10 w", 32'(w_reg), 32'(m_w));
      chk("R10 wdt frozen", 32'(wdt_prescale), 0);
      @(negedge clk);
      chk("R10 wdt resumes", 32'(wdt_prescale), 1);
      chk("R10 pd", 32'(pd_flag), 0);
      do_rotate(1'b1, 1'b0, 9, "R10 resume");
      do_rotate(1'b0, 1'b1, 100, "R10 resume");

      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule